// File: doc/BRIEF.md
# Three-Channel Compare Timer

This peripheral holds three independent counters behind a small synchronous register bus. Each counter has a software-writable count, a reload value and two compare values. Each counter runs up or down, is stepped either by the bus clock or by an external tick-enable pin, and reloads itself when it wraps past its end value. Compare hits and wraps set sticky flags in a shared status word. A mask word and the per-timer interrupt-enable bits gate those flags onto one interrupt line.

The bus is a single-cycle write strobe with a byte address and a combinational read port. A parameter picks one of two control-word layouts. In the compact layout each timer has a direction bit. In the spaced layout there are no direction bits and every timer counts down.

Top module: `tmr_triple_timer`

## Requirements
- R1: Word-aligned addresses map as follows. Timer k (k=0..2) uses base 0x10*k with count at +0x0, reload at +0x4, compare A at +0x8 and compare B at +0xC. The control word is at 0x30, the status word at 0x34 and the mask word at 0x38. Every register reads back what was last written, cut to its width: control 12 bits, status and mask 9 bits. Unmapped or unaligned addresses read 0 and ignore writes. After reset the mask is 0x1FF and every other register is 0.
- R2: In the compact layout, timer k's run bit is at 3k, its external-clock select at 3k+1, its interrupt enable at 3k+2 and its direction at 9+k, where 1 means up. A running up-counter adds one per step.
- R3: An up-counter stepping from all-ones loads its reload value and sets overflow flag 3k+2, so it wraps once every (all-ones − reload + 1) steps.
- R4: A down-counter subtracts one per step. Stepping from zero, it loads the reload value and sets overflow flag 3k+2.
- R5: Compare A flag 3k and compare B flag 3k+1 are set on the step in which the counter becomes equal to the compare value. This happens only while the timer runs. A software write of the count never sets them.
- R6: A software write of the count takes effect at once, even while running, and wins over a step. With the run bit cleared the count holds.
- R7: With the clock select set, the counter steps only on cycles where the external tick input, after a 2-flop synchroniser, is high.
- R8: A status flag stays set until software writes 0 to its bit. Writing 1 leaves it unchanged. An event in the same cycle as the clearing write keeps it set.
- R9: The interrupt output is high exactly when some status flag is set, its mask bit is 0 (1 blocks it), and its timer's interrupt-enable bit is 1.
- R10: In the spaced layout, timer k's run, select and enable bits are at 4k, 4k+1 and 4k+2, bits 4k+3 have no effect, and all timers count down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counting clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 6 | Byte address for reads and writes |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data for bus_addr |
| ext_tick | input | 1 | Asynchronous external step enable |
| irq | output | 1 | Combined interrupt |

## Verification
The properties assume that reset is held for at least one clock, that at most one register is written per cycle, and that ext_tick may change at any time, because it only reaches the counters through the synchroniser. The stability property for stopped timers assumes the count changes only through a decoded count write. The bench meets these assumptions by driving every bus write and the tick pin on falling edges. It also stops a timer before rewriting its reload or compare values, except in the deliberate collision and write-while-running cases.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the three-channel compare timer.
// Assumes the register map is fixed at three timers of four words each.
package tmr_pkg;
    localparam int NUM_TMR     = 3;
    localparam int EVT_PER_TMR = 3;
    localparam int NUM_EVT     = NUM_TMR * EVT_PER_TMR;
    localparam int CTRL_W      = 12;
    localparam int ADDR_W      = 6;

    // word indices of the shared registers
    localparam logic [3:0] WI_CTRL = 4'd12;
    localparam logic [3:0] WI_STS  = 4'd13;
    localparam logic [3:0] WI_MASK = 4'd14;

    // event positions inside one timer's three-bit group
    localparam int EVT_CMP_A = 0;
    localparam int EVT_CMP_B = 1;
    localparam int EVT_WRAP  = 2;

    typedef enum logic [1:0] {
        REG_CNT   = 2'd0,
        REG_LOAD  = 2'd1,
        REG_CMP_A = 2'd2,
        REG_CMP_B = 2'd3
    } tmr_reg_e;

    typedef struct packed {
        logic run;
        logic ext_clk;
        logic irq_en;
        logic up;
    } tmr_ctl_t;
endpackage

// File: rtl/tmr_tick_sync.sv
// Brings the asynchronous external tick pin into the clock domain.
// Assumes the pin is a level held for at least one clock period.
module tmr_tick_sync #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_async,
    output logic tick_sync
);
    logic [DEPTH-1:0] stage_q;

    // shift the pin through DEPTH flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[DEPTH-2:0], tick_async};
        end
    end

    assign tick_sync = stage_q[DEPTH-1];
endmodule

// File: rtl/tmr_ctrl_map.sv
// Decodes the control word into per-timer fields for the chosen layout.
// Assumes ALT_CTRL=0 selects the compact layout with direction bits.
module tmr_ctrl_map
    import tmr_pkg::*;
#(
    parameter bit ALT_CTRL = 1'b0
) (
    input  logic [CTRL_W-1:0] ctrl_i,
    output tmr_ctl_t          ctl_o [NUM_TMR]
);
    localparam int STRIDE = ALT_CTRL ? 4 : 3;
    localparam int DIR_LO = 9;

    logic unused_ctrl_bits;
    assign unused_ctrl_bits = ^ctrl_i;

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_map
        // pick run, select and enable bits from the timer's group
        assign ctl_o[k].run     = ctrl_i[STRIDE*k + 0];
        assign ctl_o[k].ext_clk = ctrl_i[STRIDE*k + 1];
        assign ctl_o[k].irq_en  = ctrl_i[STRIDE*k + 2];
        if (ALT_CTRL) begin : g_spaced
            // spaced layout has no direction bits: always down
            assign ctl_o[k].up = 1'b0;
        end else begin : g_compact
            assign ctl_o[k].up = ctrl_i[DIR_LO + k];
        end
    end
endmodule

// File: rtl/tmr_channel.sv
// One counter with reload and two compare registers.
// Assumes wr_en targets this channel only when the address decodes to it.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  tmr_reg_e               reg_sel,
    input  logic [CNT_W-1:0]       wr_data,
    input  tmr_ctl_t               ctl,
    input  logic                   tick_sync,
    output logic [CNT_W-1:0]       rd_data,
    output logic [CNT_W-1:0]       cnt_o,
    output logic [CNT_W-1:0]       load_o,
    output logic                   adv_o,
    output logic [EVT_PER_TMR-1:0] evt_o
);
    logic [CNT_W-1:0] cnt_q, load_q, cmp_a_q, cmp_b_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             cnt_wr, adv, wrap, fire;

    // step enable from run bit and clock source
    assign adv    = ctl.run && (ctl.ext_clk ? tick_sync : 1'b1);
    assign cnt_wr = wr_en && (reg_sel == REG_CNT);
    assign fire   = adv && !cnt_wr;

    // wrap detection and next count value
    always_comb begin
        wrap = ctl.up ? (cnt_q == {CNT_W{1'b1}}) : (cnt_q == '0);
        if (wrap) begin
            cnt_nxt = load_q;
        end else if (ctl.up) begin
            cnt_nxt = cnt_q + 1'b1;
        end else begin
            cnt_nxt = cnt_q - 1'b1;
        end
    end

    // counter: software write wins over a step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= wr_data;
        end else if (adv) begin
            cnt_q <= cnt_nxt;
        end
    end

    // reload and compare registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            cmp_a_q <= '0;
            cmp_b_q <= '0;
        end else if (wr_en) begin
            case (reg_sel)
                REG_LOAD:  load_q  <= wr_data;
                REG_CMP_A: cmp_a_q <= wr_data;
                REG_CMP_B: cmp_b_q <= wr_data;
                default:   ;
            endcase
        end
    end

    // one-cycle event pulses for the status register
    assign evt_o[EVT_CMP_A] = fire && (cnt_nxt == cmp_a_q);
    assign evt_o[EVT_CMP_B] = fire && (cnt_nxt == cmp_b_q);
    assign evt_o[EVT_WRAP]  = fire && wrap;

    // read-back mux
    always_comb begin
        case (reg_sel)
            REG_CNT:   rd_data = cnt_q;
            REG_LOAD:  rd_data = load_q;
            REG_CMP_A: rd_data = cmp_a_q;
            default:   rd_data = cmp_b_q;
        endcase
    end

    assign cnt_o  = cnt_q;
    assign load_o = load_q;
    assign adv_o  = adv;
endmodule

// File: rtl/tmr_irq_status.sv
// Sticky event flags, mask word and combined interrupt.
// Assumes events are single-cycle pulses from the channels.
module tmr_irq_status
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               sts_wr,
    input  logic               mask_wr,
    input  logic [NUM_EVT-1:0] wr_data,
    input  logic [NUM_TMR-1:0] irq_en,
    output logic [NUM_EVT-1:0] sts_o,
    output logic [NUM_EVT-1:0] mask_o,
    output logic               irq_o
);
    logic [NUM_EVT-1:0] sts_q, mask_q, ie_exp;

    // flags: write 0 clears, new events always win
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_q <= '0;
        end else begin
            sts_q <= (sts_wr ? (sts_q & wr_data) : sts_q) | evt_i;
        end
    end

    // mask word, all events blocked after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (mask_wr) begin
            mask_q <= wr_data;
        end
    end

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_ie
        assign ie_exp[EVT_PER_TMR*k +: EVT_PER_TMR] = {EVT_PER_TMR{irq_en[k]}};
    end

    assign irq_o  = |(sts_q & ~mask_q & ie_exp);
    assign sts_o  = sts_q;
    assign mask_o = mask_q;
endmodule

// File: rtl/tmr_triple_timer.sv
// Top: bus decode, control word and read mux around three channels.
// Assumes one write per cycle; reads are combinational on bus_addr.
module tmr_triple_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W      = 32,
    parameter bit ALT_CTRL   = 1'b0,
    parameter int SYNC_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              ext_tick,
    output logic              irq
);
    localparam int NUM_CH_WORDS = NUM_TMR * 4;

    logic [3:0]                word_idx;
    logic                      aligned, ch_hit;
    logic [1:0]                ch_idx;
    tmr_reg_e                  reg_sel;
    logic [CTRL_W-1:0]         ctrl_q;
    tmr_ctl_t                  ctl_v [NUM_TMR];
    logic                      tick_s;
    logic [CNT_W-1:0]          ch_rd  [NUM_TMR];
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v, load_v;
    logic [NUM_TMR-1:0]        run_v, up_v, adv_v, ie_v;
    logic [NUM_EVT-1:0]        evt_v, sts_q, mask_q;

    // address split
    assign word_idx = bus_addr[5:2];
    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign ch_hit   = aligned && (word_idx < NUM_CH_WORDS);
    assign ch_idx   = word_idx[3:2];
    assign reg_sel  = tmr_reg_e'(word_idx[1:0]);

    // control word register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (bus_wr_en && aligned && word_idx == WI_CTRL) begin
            ctrl_q <= bus_wdata[CTRL_W-1:0];
        end
    end

    tmr_ctrl_map #(.ALT_CTRL(ALT_CTRL)) u_map (
        .ctrl_i (ctrl_q),
        .ctl_o  (ctl_v)
    );

    tmr_tick_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_async (ext_tick),
        .tick_sync  (tick_s)
    );

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_ch
        logic ch_wr;
        assign ch_wr = bus_wr_en && ch_hit && (ch_idx == 2'(k));

        tmr_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ch_wr),
            .reg_sel   (reg_sel),
            .wr_data   (bus_wdata),
            .ctl       (ctl_v[k]),
            .tick_sync (tick_s),
            .rd_data   (ch_rd[k]),
            .cnt_o     (cnt_v[k]),
            .load_o    (load_v[k]),
            .adv_o     (adv_v[k]),
            .evt_o     (evt_v[EVT_PER_TMR*k +: EVT_PER_TMR])
        );

        assign run_v[k] = ctl_v[k].run;
        assign up_v[k]  = ctl_v[k].up;
        assign ie_v[k]  = ctl_v[k].irq_en;
    end

    tmr_irq_status u_sts (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_v),
        .sts_wr  (bus_wr_en && aligned && word_idx == WI_STS),
        .mask_wr (bus_wr_en && aligned && word_idx == WI_MASK),
        .wr_data (bus_wdata[NUM_EVT-1:0]),
        .irq_en  (ie_v),
        .sts_o   (sts_q),
        .mask_o  (mask_q),
        .irq_o   (irq)
    );

    // read mux over channels and shared words
    always_comb begin
        bus_rdata = '0;
        if (ch_hit) begin
            case (ch_idx)
                2'd0:    bus_rdata = ch_rd[0];
                2'd1:    bus_rdata = ch_rd[1];
                default: bus_rdata = ch_rd[2];
            endcase
        end else if (aligned) begin
            case (word_idx)
                WI_CTRL: bus_rdata = CNT_W'(ctrl_q);
                WI_STS:  bus_rdata = CNT_W'(sts_q);
                WI_MASK: bus_rdata = CNT_W'(mask_q);
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/tmr_triple_timer_chk.sv
// Property checker for the three-channel timer, bound into the top.
// Assumes it observes the top's internal counter and flag state.
module tmr_triple_timer_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_wr_en,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v,
    input logic [NUM_TMR-1:0][CNT_W-1:0] load_v,
    input logic [NUM_TMR-1:0]            run_v,
    input logic [NUM_TMR-1:0]            up_v,
    input logic [NUM_TMR-1:0]            adv_v,
    input logic [NUM_EVT-1:0]            sts_v,
    input logic [NUM_EVT-1:0]            mask_v,
    input logic                          irq
);
    logic sts_wr;
    assign sts_wr = bus_wr_en && (bus_addr == 6'h34);

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_t
        logic cnt_wr;
        assign cnt_wr = bus_wr_en && (bus_addr == 6'(16*k));

        // R6: a stopped, unwritten counter holds
        assert_cnt_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!run_v[k] && !cnt_wr) |=> $stable(cnt_v[k]));

        // R3: up wrap reloads and flags overflow
        assert_up_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (adv_v[k] && up_v[k] && cnt_v[k] == {CNT_W{1'b1}} && !cnt_wr)
            |=> (cnt_v[k] == $past(load_v[k]) && sts_v[EVT_PER_TMR*k + EVT_WRAP]));

        // R5: compare flags only rise while the timer runs
        assert_cmp_a_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_v[EVT_PER_TMR*k + EVT_CMP_A]) |-> $past(run_v[k]));
        assert_cmp_b_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(sts_v[EVT_PER_TMR*k + EVT_CMP_B]) |-> $past(run_v[k]));
    end

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_e
        // R8: flags stay set without a status write
        assert_sts_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_v[i] && !sts_wr) |=> sts_v[i]);
    end

    // R9: a fully set mask silences the interrupt
    assert_mask_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_v == {NUM_EVT{1'b1}}) |-> !irq);
endmodule

bind tmr_triple_timer tmr_triple_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr_en (bus_wr_en),
    .bus_addr  (bus_addr),
    .cnt_v     (cnt_v),
    .load_v    (load_v),
    .run_v     (run_v),
    .up_v      (up_v),
    .adv_v     (adv_v),
    .sts_v     (sts_q),
    .mask_v    (mask_q),
    .irq       (irq)
);

// File: tb/tb_tmr_triple_timer.sv
module tb_tmr_triple_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, wr_alt = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_alt;
    logic        ext_tick = 1'b0;
    logic        irq, irq_alt;
    int          checks = 0, errors = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    tmr_triple_timer #(.CNT_W(32), .ALT_CTRL(1'b0)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ext_tick(ext_tick), .irq(irq));

    tmr_triple_timer #(.CNT_W(32), .ALT_CTRL(1'b1)) dut_alt (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(wr_alt), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata_alt), .ext_tick(ext_tick), .irq(irq_alt));

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] w;
        logic [31:0] e;
    } vec_t;

    // R1: write/readback vectors, all timers stopped
    localparam vec_t VEC [0:9] = '{
        '{6'h00, 32'h1234_5678, 32'h1234_5678},
        '{6'h04, 32'hFFFF_FFF0, 32'hFFFF_FFF0},
        '{6'h08, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
        '{6'h0C, 32'h5A5A_5A5A, 32'h5A5A_5A5A},
        '{6'h14, 32'hCAFE_F00D, 32'hCAFE_F00D},
        '{6'h1C, 32'h0F0F_0F0F, 32'h0F0F_0F0F},
        '{6'h28, 32'h0123_4567, 32'h0123_4567},
        '{6'h38, 32'hFFFF_FEAA, 32'h0000_00AA},
        '{6'h34, 32'hFFFF_FFFF, 32'h0000_0000},
        '{6'h3C, 32'hDEAD_BEEF, 32'h0000_0000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic wr_alt_reg(input logic [5:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_alt = 1'b1;
        @(negedge clk);
        wr_alt = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic rd_alt(input logic [5:0] a, output logic [31:0] d);
        addr = a; #1; d = rdata_alt;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(6'h38, v); chk("R1 reset mask", v, 32'h1FF);
        rd(6'h34, v); chk("R1 reset status", v, 32'h0);
        rd(6'h30, v); chk("R1 reset ctrl", v, 32'h0);
        rd(6'h00, v); chk("R1 reset count", v, 32'h0);
        chk("R9 reset irq", {31'b0, irq}, 32'h0);

        // R1 vector walk
        for (int i = 0; i < 10; i++) begin
            wr_reg(VEC[i].a, VEC[i].w);
            rd(VEC[i].a, v);
            chk("R1 readback", v, VEC[i].e);
        end
        rd(6'h02, v); chk("R1 unaligned read", v, 32'h0);

        // R2 up count, R6 hold and write priority
        wr_reg(6'h00, 32'd100);
        wr_reg(6'h30, 32'h201);
        repeat (5) @(negedge clk);
        rd(6'h00, v); chk("R2 up count", v, 32'd105);
        wr_reg(6'h30, 32'h0);
        rd(6'h00, v); chk("R6 stop", v, 32'd106);
        repeat (5) @(negedge clk);
        rd(6'h00, v); chk("R6 hold", v, 32'd106);
        wr_reg(6'h30, 32'h201);
        wr_reg(6'h00, 32'h1000);
        rd(6'h00, v); chk("R6 write while running", v, 32'h1000);
        wr_reg(6'h30, 32'h0);

        // R3 overflow and period, R9 interrupt gating, R8 clearing
        wr_reg(6'h04, 32'hFFFF_FFF0);
        wr_reg(6'h00, 32'hFFFF_FFFE);
        wr_reg(6'h38, 32'h1FB);
        wr_reg(6'h34, 32'h0);
        wr_reg(6'h30, 32'h205);
        repeat (2) @(negedge clk);
        rd(6'h00, v); chk("R3 reload on wrap", v, 32'hFFFF_FFF0);
        rd(6'h34, v); chk("R3 overflow flag", v, 32'h4);
        chk("R9 irq unmasked", {31'b0, irq}, 32'h1);
        repeat (15) @(negedge clk);
        rd(6'h00, v); chk("R3 period end", v, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(6'h00, v); chk("R3 period wrap", v, 32'hFFFF_FFF0);
        wr_reg(6'h30, 32'h201);
        chk("R9 irq enable off", {31'b0, irq}, 32'h0);
        wr_reg(6'h30, 32'h205);
        wr_reg(6'h38, 32'h1FF);
        chk("R9 irq masked", {31'b0, irq}, 32'h0);
        wr_reg(6'h34, 32'h1FF);
        rd(6'h34, v); chk("R8 write one keeps", v, 32'h4);
        wr_reg(6'h34, 32'h1FB);
        rd(6'h34, v); chk("R8 write zero clears", v, 32'h0);
        wr_reg(6'h30, 32'h0);

        // R5 compare A then B
        wr_reg(6'h00, 32'd10);
        wr_reg(6'h08, 32'd15);
        wr_reg(6'h0C, 32'd20);
        wr_reg(6'h34, 32'h0);
        wr_reg(6'h30, 32'h201);
        repeat (4) @(negedge clk);
        rd(6'h34, v); chk("R5 before compare", v, 32'h0);
        @(negedge clk);
        rd(6'h34, v); chk("R5 compare A", v, 32'h1);
        repeat (5) @(negedge clk);
        rd(6'h34, v); chk("R5 compare B", v, 32'h3);
        wr_reg(6'h30, 32'h0);
        wr_reg(6'h34, 32'h0);
        wr_reg(6'h00, 32'd15);
        @(negedge clk);
        rd(6'h34, v); chk("R5 no flag from count write", v, 32'h0);

        // R8 event collides with clearing write
        wr_reg(6'h00, 32'd10);
        wr_reg(6'h08, 32'd13);
        wr_reg(6'h30, 32'h201);
        repeat (2) @(negedge clk);
        wr_reg(6'h34, 32'h0);
        rd(6'h34, v); chk("R8 event beats clear", v, 32'h1);
        wr_reg(6'h30, 32'h0);

        // R4 down count, compare at zero, reload
        wr_reg(6'h04, 32'd7);
        wr_reg(6'h08, 32'd0);
        wr_reg(6'h0C, 32'h1000);
        wr_reg(6'h00, 32'd3);
        wr_reg(6'h34, 32'h0);
        wr_reg(6'h30, 32'h001);
        repeat (3) @(negedge clk);
        rd(6'h00, v); chk("R4 down to zero", v, 32'd0);
        rd(6'h34, v); chk("R5 compare at zero", v, 32'h1);
        @(negedge clk);
        rd(6'h00, v); chk("R4 down reload", v, 32'd7);
        rd(6'h34, v); chk("R4 down wrap flag", v, 32'h5);
        repeat (7) @(negedge clk);
        rd(6'h00, v); chk("R4 down period", v, 32'd0);
        wr_reg(6'h30, 32'h0);

        // R7 external tick on timer 1 of 0..2 (second timer)
        wr_reg(6'h10, 32'd0);
        wr_reg(6'h30, 32'h418);
        repeat (10) @(negedge clk);
        rd(6'h10, v); chk("R7 no tick no step", v, 32'd0);
        ext_tick = 1'b1;
        repeat (6) @(negedge clk);
        ext_tick = 1'b0;
        repeat (5) @(negedge clk);
        rd(6'h10, v); chk("R7 tick count", v, 32'd6);
        wr_reg(6'h30, 32'h0);

        // R10 spaced layout
        wr_alt_reg(6'h10, 32'd5);
        wr_alt_reg(6'h30, 32'h008);
        repeat (3) @(negedge clk);
        rd_alt(6'h10, v); chk("R10 unused bit no effect", v, 32'd5);
        wr_alt_reg(6'h30, 32'h010);
        repeat (3) @(negedge clk);
        rd_alt(6'h10, v); chk("R10 spaced down count", v, 32'd2);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule